// File: doc/BRIEF.md
# Three-Wire Synthesizer Configuration Loader

This block takes configuration words for a two-channel frequency synthesizer over a write-only serial link of three wires: a serial clock, a data line and a load strobe. All three are asynchronous to the system clock. They are first synchronized into the system clock domain, and their rising edges are detected there. Each rising edge of the serial clock shifts one data bit into a 22-bit shift register, most significant bit first. When the load strobe rises, the upper 20 bits of the word are copied into one of four configuration latches. The two lowest bits of the word select which latch.

The four latches hold the following settings:
- the reference-divider setting for channel 2;
- the counter and prescaler setting for channel 2;
- the reference-divider setting for channel 1;
- the counter and prescaler setting for channel 1.

The block drives each latch's payload onto the output ports. It also decodes the 14-bit reference ratio of each channel. A sticky ready flag tells the rest of the synthesizer when every latch has been loaded at least once since reset. Power-down settings live inside the payloads, so they never stop the loader from working.

Top module: `cfg_serial_if`

## Requirements
- R1: After reset, all four latch outputs and both reference-ratio outputs are zero, and `all_loaded` is low.
- R2: A frame is shifted in MSB first, one bit per rising edge of `ser_clk`. Word bits [21:2] form the payload stored in the latch, and word bits [1:0] form the latch address.
- R3: Address 2'b00 loads `ch2_ref`, 2'b01 loads `ch2_ab`, 2'b10 loads `ch1_ref`, and 2'b11 loads `ch1_ab`. The three latches that are not addressed keep their values.
- R4: Latch contents change only when `ser_le` rises. Shifting bits while `ser_le` stays low leaves every output unchanged.
- R5: Rising edges of `ser_clk` while `ser_le` is high are ignored. A later `ser_le` rise, with no clocks in between, loads the same word again.
- R6: `ch2_ref_ratio` and `ch1_ref_ratio` equal payload bits [13:0] (word bits [15:2]) of the matching reference latch.
- R7: `all_loaded` stays low until each of the four addresses has been loaded at least once. It then goes high and stays high until reset. Loading the same address again does not count twice.
- R8: When more than 22 bits are shifted before a load, only the last 22 bits are used.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_data | input | 1 | Serial data bit |
| ser_le | input | 1 | Load strobe; rising edge transfers the word |
| ch2_ref | output | 20 | Channel-2 reference latch payload |
| ch2_ab | output | 20 | Channel-2 counter/prescaler latch payload |
| ch1_ref | output | 20 | Channel-1 reference latch payload |
| ch1_ab | output | 20 | Channel-1 counter/prescaler latch payload |
| ch2_ref_ratio | output | 14 | Channel-2 reference divide ratio |
| ch1_ref_ratio | output | 14 | Channel-1 reference divide ratio |
| all_loaded | output | 1 | High once all four latches have been loaded |

## Verification
The assertions rely on each serial line holding its level for at least three system clocks. With that spacing, the synchronizers see every edge exactly once. The assertions also rely on `ser_clk` being low and settled before `ser_le` rises, so that no shift and no load fall in the same cycle.

The stimulus holds every phase of the serial clock, and each high and low half of the strobe, for four to six system clocks. It changes inputs only on falling edges of the system clock. Outputs are compared only after the strobe has gone low again, by which time the three-register path from strobe to latch has settled.

// File: rtl/cfg_serial_pkg.sv
package cfg_serial_pkg;
    localparam int WORD_W      = 22;
    localparam int ADDR_W      = 2;
    localparam int REF_W       = 14;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        SEL_CH2_REF = 2'b00,
        SEL_CH2_AB  = 2'b01,
        SEL_CH1_REF = 2'b10,
        SEL_CH1_AB  = 2'b11
    } latch_sel_e;
endpackage

// File: rtl/cfg_edge_sync.sv
module cfg_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level,
    output logic rise
);
    typedef struct packed {
        logic [STAGES:0] pipe;
    } sync_state_t;

    sync_state_t state_d, state_q;

    always_comb begin
        state_d      = state_q;
        state_d.pipe = {state_q.pipe[STAGES-1:0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign level = state_q.pipe[STAGES-1];
    assign rise  = state_q.pipe[STAGES-1] & ~state_q.pipe[STAGES];
endmodule

// File: rtl/cfg_shift_reg.sv
module cfg_shift_reg #(
    parameter int WIDTH = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             bit_in,
    output logic [WIDTH-1:0] word
);
    typedef struct packed {
        logic [WIDTH-1:0] sreg;
    } shift_state_t;

    shift_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (shift_en) begin
            state_d.sreg = {state_q.sreg[WIDTH-2:0], bit_in};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign word = state_q.sreg;
endmodule

// File: rtl/cfg_latch_bank.sv
module cfg_latch_bank #(
    parameter int PAY_W  = 20,
    parameter int ADDR_W = 2,
    localparam int NUM_LATCH = 1 << ADDR_W
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            load,
    input  logic [ADDR_W-1:0]               addr,
    input  logic [PAY_W-1:0]                payload,
    output logic [NUM_LATCH-1:0][PAY_W-1:0] latches,
    output logic [NUM_LATCH-1:0]            written,
    output logic                            ready
);
    typedef struct packed {
        logic [NUM_LATCH-1:0][PAY_W-1:0] data;
        logic [NUM_LATCH-1:0]            seen;
        logic                            ready;
    } bank_state_t;

    bank_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        for (int i = 0; i < NUM_LATCH; i++) begin
            if (load && (addr == ADDR_W'(i))) begin
                state_d.data[i] = payload;
                state_d.seen[i] = 1'b1;
            end
        end
        state_d.ready = &state_d.seen;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign latches = state_q.data;
    assign written = state_q.seen;
    assign ready   = state_q.ready;
endmodule

// File: rtl/cfg_serial_if.sv
module cfg_serial_if
    import cfg_serial_pkg::*;
#(
    parameter int WORD_BITS  = cfg_serial_pkg::WORD_W,
    parameter int SEL_BITS   = cfg_serial_pkg::ADDR_W,
    parameter int RATIO_BITS = cfg_serial_pkg::REF_W,
    parameter int SYNC_DEPTH = cfg_serial_pkg::SYNC_STAGES,
    localparam int PAY_BITS  = WORD_BITS - SEL_BITS,
    localparam int N_LATCH   = 1 << SEL_BITS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ser_clk,
    input  logic                  ser_data,
    input  logic                  ser_le,
    output logic [PAY_BITS-1:0]   ch2_ref,
    output logic [PAY_BITS-1:0]   ch2_ab,
    output logic [PAY_BITS-1:0]   ch1_ref,
    output logic [PAY_BITS-1:0]   ch1_ab,
    output logic [RATIO_BITS-1:0] ch2_ref_ratio,
    output logic [RATIO_BITS-1:0] ch1_ref_ratio,
    output logic                  all_loaded
);
    logic                               sclk_level, sclk_rise;
    logic                               le_level, le_rise;
    logic                               sdata_level, sdata_rise;
    logic                               shift_en;
    logic [WORD_BITS-1:0]               word;
    logic [N_LATCH-1:0][PAY_BITS-1:0]   latches;
    logic [N_LATCH-1:0]                 written;

    cfg_edge_sync #(.STAGES(SYNC_DEPTH)) u_sync_sclk (
        .clk(clk), .rst_n(rst_n), .async_in(ser_clk),
        .level(sclk_level), .rise(sclk_rise)
    );
    cfg_edge_sync #(.STAGES(SYNC_DEPTH)) u_sync_le (
        .clk(clk), .rst_n(rst_n), .async_in(ser_le),
        .level(le_level), .rise(le_rise)
    );
    cfg_edge_sync #(.STAGES(SYNC_DEPTH)) u_sync_data (
        .clk(clk), .rst_n(rst_n), .async_in(ser_data),
        .level(sdata_level), .rise(sdata_rise)
    );

    assign shift_en = sclk_rise & ~le_level;

    cfg_shift_reg #(.WIDTH(WORD_BITS)) u_shift (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en),
        .bit_in(sdata_level), .word(word)
    );

    cfg_latch_bank #(.PAY_W(PAY_BITS), .ADDR_W(SEL_BITS)) u_bank (
        .clk(clk), .rst_n(rst_n), .load(le_rise),
        .addr(word[SEL_BITS-1:0]), .payload(word[WORD_BITS-1:SEL_BITS]),
        .latches(latches), .written(written), .ready(all_loaded)
    );

    assign ch2_ref       = latches[SEL_CH2_REF];
    assign ch2_ab        = latches[SEL_CH2_AB];
    assign ch1_ref       = latches[SEL_CH1_REF];
    assign ch1_ab        = latches[SEL_CH1_AB];
    assign ch2_ref_ratio = ch2_ref[RATIO_BITS-1:0];
    assign ch1_ref_ratio = ch1_ref[RATIO_BITS-1:0];
endmodule

// File: rtl/cfg_serial_if_chk.sv
module cfg_serial_if_chk #(
    parameter int WORD_BITS = 22,
    parameter int PAY_BITS  = 20,
    parameter int N_LATCH   = 4
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             le_rise,
    input logic                             le_level,
    input logic                             sclk_rise,
    input logic [WORD_BITS-1:0]             word,
    input logic [N_LATCH-1:0][PAY_BITS-1:0] latches,
    input logic [N_LATCH-1:0]               written,
    input logic                             all_loaded
);
    // R4
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !le_rise |=> $stable(latches));

    // R5
    shift_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (le_level && sclk_rise) |=> $stable(word));

    // R7
    ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        all_loaded |=> all_loaded);

    // R7
    ready_needs_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        all_loaded |-> (&written));

    // R3
    one_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        le_rise |=> ($countones(latches ^ $past(latches)) <= PAY_BITS));

    // R2
    load_copies_chk: assert property (@(posedge clk) disable iff (!rst_n)
        le_rise |=> (latches[$past(word[1:0])] == $past(word[WORD_BITS-1:2])));
endmodule

bind cfg_serial_if cfg_serial_if_chk #(
    .WORD_BITS(WORD_BITS), .PAY_BITS(PAY_BITS), .N_LATCH(N_LATCH)
) u_chk (
    .clk(clk), .rst_n(rst_n), .le_rise(le_rise), .le_level(le_level),
    .sclk_rise(sclk_rise), .word(word), .latches(latches),
    .written(written), .all_loaded(all_loaded)
);

// File: tb/cfg_serial_if_tb.sv
module cfg_serial_if_tb;
    localparam int PW = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;
    logic [PW-1:0] ch2_ref, ch2_ab, ch1_ref, ch1_ab;
    logic [13:0]   ch2_ref_ratio, ch1_ref_ratio;
    logic          all_loaded;

    int checks = 0;
    int failures = 0;

    typedef struct {
        logic          do_load;
        logic [1:0]    addr;
        logic [PW-1:0] payload;
        string         tag;
    } sb_item_t;

    sb_item_t sb_q[$];
    logic [PW-1:0] model [4];
    logic [3:0]    model_seen;

    always #5 clk = ~clk;

    cfg_serial_if u_dut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_le(ser_le), .ch2_ref(ch2_ref), .ch2_ab(ch2_ab), .ch1_ref(ch1_ref),
        .ch1_ab(ch1_ab), .ch2_ref_ratio(ch2_ref_ratio),
        .ch1_ref_ratio(ch1_ref_ratio), .all_loaded(all_loaded)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        ser_data = b;
        wait_clk(4);
        ser_clk = 1'b1;
        wait_clk(4);
        ser_clk = 1'b0;
    endtask

    task automatic shift_word(input logic [21:0] w);
        for (int i = 21; i >= 0; i--) send_bit(w[i]);
    endtask

    task automatic pulse_le();
        wait_clk(4);
        ser_le = 1'b1;
        wait_clk(6);
        ser_le = 1'b0;
        wait_clk(6);
    endtask

    task automatic push(input logic ld, input logic [1:0] a, input logic [PW-1:0] p, input string tag);
        sb_item_t it;
        it.do_load = ld; it.addr = a; it.payload = p; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic write_frame(input logic [1:0] a, input logic [PW-1:0] p, input string tag);
        shift_word({p, a});
        pulse_le();
        push(1'b1, a, p, tag);
        wait_clk(2);
    endtask

    // Monitor: pops expected items and compares all outputs with the model
    initial begin
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                sb_item_t it;
                it = sb_q.pop_front();
                if (it.do_load) begin
                    model[it.addr] = it.payload;
                    model_seen[it.addr] = 1'b1;
                end
                chk({it.tag, " R3 ch2_ref"}, 32'(ch2_ref), 32'(model[0]));
                chk({it.tag, " R3 ch2_ab"},  32'(ch2_ab),  32'(model[1]));
                chk({it.tag, " R3 ch1_ref"}, 32'(ch1_ref), 32'(model[2]));
                chk({it.tag, " R3 ch1_ab"},  32'(ch1_ab),  32'(model[3]));
                chk({it.tag, " R6 ch2_ratio"}, 32'(ch2_ref_ratio), 32'(model[0][13:0]));
                chk({it.tag, " R6 ch1_ratio"}, 32'(ch1_ref_ratio), 32'(model[2][13:0]));
                chk({it.tag, " R7 all_loaded"}, 32'(all_loaded), 32'(&model_seen));
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog R1 actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) model[i] = '0;
        model_seen = '0;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);
        // R1 reset state
        chk("R1 ch2_ref", 32'(ch2_ref), 0);
        chk("R1 ch1_ab", 32'(ch1_ab), 0);
        chk("R1 ratio", 32'(ch1_ref_ratio), 0);
        chk("R1 all_loaded", 32'(all_loaded), 0);

        // R2/R3/R6/R7: load addresses in a scrambled order with a repeat
        write_frame(2'b00, 20'hA5C3E, "R2 R6 a00");
        write_frame(2'b00, 20'h3FFFF, "R7 repeat a00");
        write_frame(2'b10, 20'h80001, "R6 a10");
        write_frame(2'b01, 20'h12345, "R3 a01");
        write_frame(2'b11, 20'hFEDCB, "R7 a11 final");

        // R4: shift without a strobe, outputs must not move
        shift_word({20'h0F0F0, 2'b10});
        wait_clk(6);
        push(1'b0, 2'b00, '0, "R4 no strobe");
        wait_clk(2);
        pulse_le();
        push(1'b1, 2'b10, 20'h0F0F0, "R4 late strobe");
        wait_clk(2);

        // R5: clocks during strobe high are ignored, re-strobe reloads same word
        write_frame(2'b01, 20'h55AA5, "R5 base");
        ser_le = 1'b1;
        wait_clk(6);
        for (int i = 0; i < 22; i++) send_bit(1'b1);
        ser_le = 1'b0;
        wait_clk(6);
        pulse_le();
        push(1'b1, 2'b01, 20'h55AA5, "R5 reload");
        wait_clk(2);

        // R8: extra leading bits are dropped
        for (int i = 0; i < 5; i++) send_bit(1'b1);
        write_frame(2'b11, 20'h00007, "R8 overlong");

        // R7: sticky after reloads of a single address
        write_frame(2'b00, 20'h00001, "R7 sticky");

        wait (sb_q.size() == 0);
        wait_clk(3);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule